// File: doc/BRIEF.md
# Event Interrupt Aggregator

This block gathers single-cycle event strobes from a serial audio bus controller into a sticky status register. Each event bit can reach the processor only through two gates: a per-bit mask and a per-bit CPU-enable. Software reads the status, handles the events, and retires them by writing ones to a write-one-to-clear register. A single interrupt line combines every event that passes both gates.

A configuration register has two bits. One is a global enable that forces the line low. The other selects between a level output and a one-cycle pulse on each new rising edge of the combined condition. Events keep latching while the line is disabled. A read-only identification word, fixed by parameters, reports a major number, a minor number and a step number.

All access goes through a simple synchronous register port. It has a byte address, a write strobe, a read strobe and 32-bit data, and read data is registered. An event that arrives in the same cycle as a clear of its bit always survives. Software can therefore clear the status before it issues follow-on commands, and it never loses the completion that those commands produce.

Top module: `irq_agg`

## Requirements
- R1: After reset the status, mask, CPU-enable and configuration registers are zero, `irq_o` is low and `rd_data_o` is zero.
- R2: A read at offset 0x000 returns {major[31:24], minor[23:16], step[15:0]} from the parameters. Writes to that offset change nothing.
- R3: When event input bit i is high at a clock edge, status bit i (read at offset 0x200) is 1 after that edge and stays 1 until it is cleared. Writes to offset 0x200 do not change the status.
- R4: Writing value V at offset 0x208 clears every status bit that is set in V and leaves every other status bit unchanged. A read at offset 0x208 returns 0.
- R5: If an event bit and a clear of the same bit fall on the same edge, the status bit is 1 after that edge.
- R6: Status bit i contributes to the interrupt only when mask bit i (offset 0x204) and CPU-enable bit i (offset 0x210) are both 1.
- R7: In level mode (configuration bit 1 = 0, at offset 0x004), `irq_o` is high one cycle after any contributing status bit is set and enable is 1. It stays high as long as the condition holds.
- R8: In pulse mode (configuration bit 1 = 1), `irq_o` is high for exactly one cycle, one cycle after the combined condition rises. It stays low while the condition remains high.
- R9: While configuration bit 0 (enable) is 0, `irq_o` is low, and status bits still latch events.
- R10: A read strobe at an edge loads `rd_data_o` with the addressed register's value from before that edge. Offsets that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_EVT | Event strobes, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte offset of the access |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt line, level or pulse |

## Verification
The hardest case to reach is an event landing on the exact edge that clears its bit. The bench drives the event strobe and the clear write in the same half-cycle, with an unrelated bit already pending in the same clear value. This shows that the clear takes the other bit away and leaves the new one. Pulse mode is also exercised with a second event arriving while the first is still pending, which must not retrigger the line. Every event bit is swept in turn through latch, ignored status write and clear.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_VER = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_STS = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_MSK = 12'h204;
  localparam logic [ADDR_W-1:0] OFS_CLR = 12'h208;
  localparam logic [ADDR_W-1:0] OFS_CEN = 12'h210;

  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_PULSE_BIT = 1;

  function automatic logic [31:0] pack_ver(input logic [7:0] maj,
                                           input logic [7:0] mnr,
                                           input logic [15:0] stp);
    return {maj, mnr, stp};
  endfunction

endpackage

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int N_EVT = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] clr_i,
  output logic [N_EVT-1:0] sts_o
);

  logic [N_EVT-1:0] sts_q;

  for (genvar g = 0; g < N_EVT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) sts_q[g] <= 1'b0;
      else     sts_q[g] <= evt_i[g] | (sts_q[g] & ~clr_i[g]);
    end

    // R5: a new event wins over a simultaneous clear
    p_evt_sets_r5: assert property (@(posedge clk) disable iff (rst)
      evt_i[g] |=> sts_q[g]);

    // R4: a clear without a new event empties the bit
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !evt_i[g]) |=> !sts_q[g]);

    // R3: the bit stays set until it is cleared
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      (sts_q[g] && !clr_i[g]) |=> sts_q[g]);
  end

  assign sts_o = sts_q;

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int          N_EVT   = 17,
  parameter logic [31:0] VERSION = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [N_EVT-1:0]  sts_i,
  output logic [N_EVT-1:0]  mask_o,
  output logic [N_EVT-1:0]  cen_o,
  output logic              en_o,
  output logic              pulse_o,
  output logic [N_EVT-1:0]  clr_o,
  output logic [31:0]       rd_data_o
);

  logic [N_EVT-1:0] mask_q;
  logic [N_EVT-1:0] cen_q;
  logic [1:0]       cfg_q;
  logic [31:0]      rd_q;
  logic [31:0]      rd_mux;
  logic             wr_msk, wr_cen, wr_cfg, wr_clr;
  logic             unused_wbits;

  assign unused_wbits = ^wr_data_i;

  assign wr_cfg = wr_en_i && (addr_i == OFS_CFG);
  assign wr_msk = wr_en_i && (addr_i == OFS_MSK);
  assign wr_cen = wr_en_i && (addr_i == OFS_CEN);
  assign wr_clr = wr_en_i && (addr_i == OFS_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      cen_q  <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_msk) mask_q <= wr_data_i[N_EVT-1:0];
      if (wr_cen) cen_q  <= wr_data_i[N_EVT-1:0];
      if (wr_cfg) cfg_q  <= wr_data_i[1:0];
    end
  end

  always_comb begin
    rd_mux = 32'h0;
    case (addr_i)
      OFS_VER: rd_mux = VERSION;
      OFS_CFG: rd_mux = {30'h0, cfg_q};
      OFS_STS: rd_mux = 32'(sts_i);
      OFS_MSK: rd_mux = 32'(mask_q);
      OFS_CEN: rd_mux = 32'(cen_q);
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= 32'h0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign clr_o     = wr_clr ? wr_data_i[N_EVT-1:0] : '0;
  assign mask_o    = mask_q;
  assign cen_o     = cen_q;
  assign en_o      = cfg_q[CFG_EN_BIT];
  assign pulse_o   = cfg_q[CFG_PULSE_BIT];
  assign rd_data_o = rd_q;

  // R6: the mask changes only through its own offset
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_msk |=> $stable(mask_q));

  // R10: read data holds without a read strobe
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_q));

  // R2: the identification word is what the port returns
  p_ver_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == OFS_VER) |=> (rd_q == VERSION));

endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
  parameter int N_EVT = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             pulse_i,
  input  logic [N_EVT-1:0] sts_i,
  input  logic [N_EVT-1:0] mask_i,
  input  logic [N_EVT-1:0] cen_i,
  output logic             irq_o
);

  logic any_w;
  logic gated_w;
  logic gated_d;
  logic irq_q;

  assign any_w   = |(sts_i & mask_i & cen_i);
  assign gated_w = en_i & any_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      gated_d <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      gated_d <= gated_w;
      irq_q   <= pulse_i ? (gated_w & ~gated_d) : gated_w;
    end
  end

  assign irq_o = irq_q;

  // R9: disabled output stays low
  p_off_low_r9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_q);

  // R7: level mode follows the pending condition
  p_level_r7: assert property (@(posedge clk) disable iff (rst)
    (!pulse_i && en_i && any_w) |=> irq_q);

  // R8: pulse mode never holds for two cycles
  p_pulse_one_r8: assert property (@(posedge clk) disable iff (rst)
    (pulse_i && irq_q) |=> !irq_q);

  // R6: nothing passes without a gated source
  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !any_w |=> !irq_q);

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int          N_EVT     = 17,
  parameter logic [7:0]  VER_MAJOR = 8'h01,
  parameter logic [7:0]  VER_MINOR = 8'h05,
  parameter logic [15:0] VER_STEP  = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);

  localparam logic [31:0] VERSION = pack_ver(VER_MAJOR, VER_MINOR, VER_STEP);

  logic [N_EVT-1:0] sts_w, mask_w, cen_w, clr_w;
  logic             en_w, pulse_w;

  irq_agg_status #(.N_EVT(N_EVT)) status_i (
    .clk   (clk),
    .rst   (rst),
    .evt_i (evt_i),
    .clr_i (clr_w),
    .sts_o (sts_w)
  );

  irq_agg_regs #(.N_EVT(N_EVT), .VERSION(VERSION)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .sts_i     (sts_w),
    .mask_o    (mask_w),
    .cen_o     (cen_w),
    .en_o      (en_w),
    .pulse_o   (pulse_w),
    .clr_o     (clr_w),
    .rd_data_o (rd_data_o)
  );

  irq_agg_out #(.N_EVT(N_EVT)) out_i (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_w),
    .pulse_i (pulse_w),
    .sts_i   (sts_w),
    .mask_i  (mask_w),
    .cen_i   (cen_w),
    .irq_o   (irq_o)
  );

endmodule

// File: tb/irq_agg_tb_top.sv
module irq_agg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 17;
  localparam logic [31:0] ALL = 32'h0001_FFFF;
  localparam logic [31:0] EXP_VER = 32'h0105_0001;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] evt = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_agg dut_i (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    cyc();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic fire(input logic [31:0] bits);
    evt = bits[NE-1:0];
    cyc();
    evt = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc();

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rd(12'h200, v); chk("R1 status", v, 32'h0);
    rd(12'h004, v); chk("R1 cfg", v, 32'h0);
    rd(12'h204, v); chk("R1 mask", v, 32'h0);
    rd(12'h210, v); chk("R1 cen", v, 32'h0);

    // R2 version, read-only
    rd(12'h000, v); chk("R2 version", v, EXP_VER);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R2 version after write", v, EXP_VER);

    // R10 unmapped offset
    rd(12'h100, v); chk("R10 unmapped", v, 32'h0);

    // level mode, all gates open
    wr(12'h204, ALL);
    wr(12'h210, ALL);
    wr(12'h004, 32'h1);
    rd(12'h204, v); chk("R10 mask readback", v, ALL);

    // sweep every event bit: R3, R4, R7
    for (int i = 0; i < NE; i++) begin
      fire(32'h1 << i);
      chk("R7 irq registered one cycle later", {31'h0, irq}, 32'h0);
      rd(12'h200, v); chk("R3 status latch", v, 32'h1 << i);
      chk("R7 level high", {31'h0, irq}, 32'h1);
      wr(12'h200, 32'h0);
      rd(12'h200, v); chk("R3 status write ignored", v, 32'h1 << i);
      chk("R7 level held", {31'h0, irq}, 32'h1);
      wr(12'h208, 32'h1 << i);
      cyc();
      chk("R7 level low after clear", {31'h0, irq}, 32'h0);
      rd(12'h200, v); chk("R4 cleared", v, 32'h0);
    end

    // R4 partial clear, clear register reads zero
    fire(ALL);
    wr(12'h208, 32'h0000_0486);
    rd(12'h200, v); chk("R4 partial clear", v, ALL & ~32'h0000_0486);
    rd(12'h208, v); chk("R4 clear reads zero", v, 32'h0);
    wr(12'h208, ALL);

    // R5 event and clear on the same edge
    fire(32'h8);
    evt = NE'(32'h80);
    wr_en = 1'b1; addr = 12'h208; wdata = 32'h88;
    cyc();
    evt = '0; wr_en = 1'b0;
    rd(12'h200, v); chk("R5 collision keeps event", v, 32'h80);
    wr(12'h208, ALL);

    // R6 gating by mask and cpu enable
    for (int b = 0; b < 3; b++) begin
      int bit_n;
      bit_n = (b == 0) ? 0 : ((b == 1) ? 10 : 16);
      for (int c = 0; c < 4; c++) begin
        wr(12'h208, ALL);
        wr(12'h204, c[0] ? (32'h1 << bit_n) : (ALL & ~(32'h1 << bit_n)));
        wr(12'h210, c[1] ? (32'h1 << bit_n) : (ALL & ~(32'h1 << bit_n)));
        fire(32'h1 << bit_n);
        cyc();
        chk("R6 gate", {31'h0, irq}, {31'h0, c[0] & c[1]});
      end
    end
    wr(12'h208, ALL);
    wr(12'h204, ALL);
    wr(12'h210, ALL);

    // R8 pulse mode
    wr(12'h004, 32'h3);
    cyc();
    fire(32'h4);
    chk("R8 pulse not yet", {31'h0, irq}, 32'h0);
    cyc();
    chk("R8 pulse high", {31'h0, irq}, 32'h1);
    cyc();
    chk("R8 pulse one cycle", {31'h0, irq}, 32'h0);
    fire(32'h2);
    cyc();
    chk("R8 no retrigger while pending", {31'h0, irq}, 32'h0);
    wr(12'h208, ALL);
    cyc();
    fire(32'h2);
    cyc();
    chk("R8 pulse after re-arm", {31'h0, irq}, 32'h1);
    cyc();
    chk("R8 pulse ends", {31'h0, irq}, 32'h0);
    wr(12'h208, ALL);

    // R9 disabled output, status still latches
    wr(12'h004, 32'h0);
    fire(32'h80);
    cyc();
    cyc();
    chk("R9 irq low while disabled", {31'h0, irq}, 32'h0);
    rd(12'h200, v); chk("R9 status still latches", v, 32'h80);
    wr(12'h004, 32'h1);
    cyc();
    chk("R9 irq after enable", {31'h0, irq}, 32'h1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule